// File: doc/BRIEF.md
# SEC-DED ECC Engine with Diagnostic Test Mode

This block protects a 64-bit memory word with eight check bits. These form an extended Hamming code, and the extra overall-parity bit tells a single flipped bit apart from two flipped bits. On the write path it computes the check bits for the word being stored. On the read path it takes the stored word and its check bits, recomputes the syndrome and repairs any one wrong bit. It flags two wrong bits as unrepairable and records the outcome in a sticky status field. A real-time error output pulses alongside the decoded word, and a tag travels with each read, so the host learns exactly which access failed. One configuration input chooses whether that pulse marks repaired reads or unrepairable ones.

A diagnostic mode lets the host reach the coding logic directly. With test mode enabled, the normal read and write requests are ignored. An encode request returns the host's pattern together with the check bits the encoder produced for it. A decode request feeds host-chosen data and check bits, possibly with planted faults, through the decoder, and returns the result through the normal read outputs. The intended use is to run this check sequence once after every power-up, so that a broken encoder or decoder is caught before it can hide a real memory fault.

Top module: `secded_engine`

## Requirements
- R1: One cycle after `wr_valid` (test mode off), `enc_valid` is high, `enc_data` equals the written word and `enc_chk` holds its check bits. Data bit i sits at the i-th code position, counting from 3 upward and skipping powers of two. `enc_chk[k]` (k = 0..6) is the XOR of the data bits whose position has bit k set. `enc_chk[7]` is the XOR of all 64 data bits and `enc_chk[6:0]`.
- R2: `status` encodes the last decode as 2'b00 clean, 2'b01 corrected, 2'b10 uncorrectable. It never holds 2'b11, and it reads 2'b00 after reset.
- R3: A read with exactly one flipped data bit returns the original word one cycle after `rd_valid`, with `dec_valid` high and status 2'b01.
- R4: A read with two flipped bits (data, check, or one of each) returns status 2'b10 and passes the received data through unchanged.
- R5: A read where only one check bit, including the overall parity bit `rd_chk[7]`, is flipped returns status 2'b01 with the data unchanged.
- R6: `err_pin` is high only in the cycle that `dec_valid` is high for the affected read, and `dec_tag` then carries that read's `rd_tag`. With `cfg_err_sel` = 1 it marks corrected reads, with 0 it marks uncorrectable reads, and it is never high for a clean read.
- R7: A clean read returns the word unchanged with status 2'b00.
- R8: `status` holds its value in every cycle without a decode, including across encode operations.
- R9: While `tm_en` is high, `wr_valid` and `rd_valid` have no effect: no output valid rises and status is unchanged.
- R10: In test mode, `tm_valid` with `tm_op` = 0 returns `tm_data` on `enc_data` and its R1 check bits on `enc_chk` one cycle later.
- R11: In test mode, `tm_valid` with `tm_op` = 1 decodes `tm_data`/`tm_chk` exactly as a read would. It updates status and `err_pin` and returns `dec_tag` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_err_sel | input | 1 | 1: error pin marks corrected reads; 0: marks uncorrectable reads |
| wr_valid | input | 1 | Write encode request |
| wr_data | input | 64 | Word to be written |
| rd_valid | input | 1 | Read decode request |
| rd_data | input | 64 | Word read from memory |
| rd_chk | input | 8 | Check bits read from memory |
| rd_tag | input | 16 | Location tag of the read |
| tm_en | input | 1 | Diagnostic test mode enable |
| tm_op | input | 1 | Test operation: 0 encode, 1 decode |
| tm_valid | input | 1 | Test operation request |
| tm_data | input | 64 | Host-supplied test data |
| tm_chk | input | 8 | Host-supplied test check bits |
| enc_valid | output | 1 | Encoder result valid |
| enc_data | output | 64 | Data accompanying the check bits |
| enc_chk | output | 8 | Generated check bits |
| dec_valid | output | 1 | Decoder result valid |
| dec_data | output | 64 | Decoded (possibly corrected) word |
| dec_tag | output | 16 | Tag of the decoded access |
| err_pin | output | 1 | Real-time error indication |
| status | output | 2 | Outcome of the last decode |

## Verification
The assertions assume that every request input is driven to a known level from the first cycle after reset. They also assume that `tm_op` only matters while `tm_en` is high, and they relate the error pin to the value `cfg_err_sel` had in the cycle the request was presented. The stimulus changes inputs only on the falling clock edge and holds each request for a single cycle followed by an idle cycle. It changes `cfg_err_sel` only while no request is in flight, so every expected result belongs to one request and one configuration.

// File: rtl/secded_pkg.sv
`timescale 1ns/1ps
package secded_pkg;

    localparam int DATA_W  = 64;
    localparam int TAG_W   = 16;

    function automatic int ham_bits(input int n);
        int r;
        r = 1;
        while ((1 << r) < (n + r + 1)) r++;
        return r;
    endfunction

    localparam int HAM_W = ham_bits(DATA_W);
    localparam int CHK_W = HAM_W + 1;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [CHK_W-1:0]  chk_t;
    typedef logic [HAM_W-1:0]  syn_t;
    typedef logic [TAG_W-1:0]  tag_t;

    typedef enum logic [1:0] {
        OUT_CLEAN = 2'b00,
        OUT_FIXED = 2'b01,
        OUT_FATAL = 2'b10
    } outcome_e;

    typedef enum logic {
        TOP_ENC = 1'b0,
        TOP_DEC = 1'b1
    } test_op_e;

    typedef struct packed {
        word_t    data;
        outcome_e outcome;
    } dec_res_t;

    // Code position of data bit idx: positions 3,5,6,7,9,... (powers of two skipped)
    function automatic int data_pos(input int idx);
        int pos;
        int cnt;
        pos = 2;
        cnt = -1;
        while (cnt < idx) begin
            pos++;
            if ((pos & (pos - 1)) != 0) cnt++;
        end
        return pos;
    endfunction

    // Data bits covered by Hamming check bit k
    function automatic word_t cover_mask(input int k);
        word_t m;
        m = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (((data_pos(i) >> k) & 1) == 1) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/secded_encoder.sv
`timescale 1ns/1ps
module secded_encoder
    import secded_pkg::*;
(
    input  word_t data,
    output chk_t  chk
);
    syn_t ham;

    for (genvar k = 0; k < HAM_W; k++) begin : g_ham
        localparam word_t MASK = cover_mask(k);
        assign ham[k] = ^(data & MASK);
    end

    assign chk = {(^data) ^ (^ham), ham};
endmodule

// File: rtl/secded_decoder.sv
`timescale 1ns/1ps
module secded_decoder
    import secded_pkg::*;
(
    input  word_t    data,
    input  chk_t     chk,
    output dec_res_t res
);
    chk_t  calc;
    syn_t  syn;
    word_t hit;
    logic  par_err;
    logic  syn_zero;
    logic  syn_chk;
    logic  data_hit;

    secded_encoder u_recalc (
        .data (data),
        .chk  (calc)
    );

    assign syn      = chk[HAM_W-1:0] ^ calc[HAM_W-1:0];
    assign par_err  = ^{data, chk};
    assign syn_zero = (syn == '0);
    assign syn_chk  = $onehot(syn);

    for (genvar i = 0; i < DATA_W; i++) begin : g_hit
        localparam syn_t POS = syn_t'(data_pos(i));
        assign hit[i] = (syn == POS);
    end

    assign data_hit = |hit;

    always_comb begin
        res.data    = data;
        res.outcome = OUT_FATAL;
        if (!par_err && syn_zero) begin
            res.outcome = OUT_CLEAN;
        end else if (par_err && (syn_zero || syn_chk)) begin
            res.outcome = OUT_FIXED;
        end else if (par_err && data_hit) begin
            res.outcome = OUT_FIXED;
            res.data    = data ^ hit;
        end
    end
endmodule

// File: rtl/secded_status.sv
`timescale 1ns/1ps
module secded_status
    import secded_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     upd,
    input  outcome_e outcome_in,
    output outcome_e status
);
    always_ff @(posedge clk) begin
        if (rst) begin
            status <= OUT_CLEAN;
        end else if (upd) begin
            status <= outcome_in;
        end
    end
endmodule

// File: rtl/secded_engine.sv
`timescale 1ns/1ps
module secded_engine
    import secded_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_err_sel,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [CHK_W-1:0]  rd_chk,
    input  logic [TAG_W-1:0]  rd_tag,
    input  logic              tm_en,
    input  logic              tm_op,
    input  logic              tm_valid,
    input  logic [DATA_W-1:0] tm_data,
    input  logic [CHK_W-1:0]  tm_chk,
    output logic              enc_valid,
    output logic [DATA_W-1:0] enc_data,
    output logic [CHK_W-1:0]  enc_chk,
    output logic              dec_valid,
    output logic [DATA_W-1:0] dec_data,
    output logic [TAG_W-1:0]  dec_tag,
    output logic              err_pin,
    output logic [1:0]        status
);
    test_op_e op;
    logic     enc_go;
    logic     dec_go;
    word_t    enc_src;
    word_t    dec_src;
    chk_t     dec_src_chk;
    chk_t     enc_calc;
    dec_res_t dec_res;
    logic     err_now;
    outcome_e status_q;

    assign op          = test_op_e'(tm_op);
    assign enc_go      = tm_en ? (tm_valid && op == TOP_ENC) : wr_valid;
    assign dec_go      = tm_en ? (tm_valid && op == TOP_DEC) : rd_valid;
    assign enc_src     = tm_en ? tm_data : wr_data;
    assign dec_src     = tm_en ? tm_data : rd_data;
    assign dec_src_chk = tm_en ? tm_chk  : rd_chk;

    secded_encoder u_enc (
        .data (enc_src),
        .chk  (enc_calc)
    );

    secded_decoder u_dec (
        .data (dec_src),
        .chk  (dec_src_chk),
        .res  (dec_res)
    );

    assign err_now = cfg_err_sel ? (dec_res.outcome == OUT_FIXED)
                                 : (dec_res.outcome == OUT_FATAL);

    always_ff @(posedge clk) begin
        if (rst) begin
            enc_valid <= 1'b0;
            enc_data  <= '0;
            enc_chk   <= '0;
        end else begin
            enc_valid <= enc_go;
            if (enc_go) begin
                enc_data <= enc_src;
                enc_chk  <= enc_calc;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dec_valid <= 1'b0;
            dec_data  <= '0;
            dec_tag   <= '0;
            err_pin   <= 1'b0;
        end else begin
            dec_valid <= dec_go;
            err_pin   <= dec_go && err_now;
            if (dec_go) begin
                dec_data <= dec_res.data;
                dec_tag  <= tm_en ? '0 : rd_tag;
            end
        end
    end

    secded_status u_status (
        .clk        (clk),
        .rst        (rst),
        .upd        (dec_go),
        .outcome_in (dec_res.outcome),
        .status     (status_q)
    );

    assign status = status_q;
endmodule

// File: rtl/secded_engine_chk.sv
`timescale 1ns/1ps
module secded_engine_chk (
    input logic       clk,
    input logic       rst,
    input logic       cfg_err_sel,
    input logic       wr_valid,
    input logic       rd_valid,
    input logic       tm_en,
    input logic       tm_valid,
    input logic       enc_valid,
    input logic       dec_valid,
    input logic       err_pin,
    input logic [1:0] status
);
    AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (rst)
        status != 2'b11);  // R2

    AST_ERR_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
        err_pin |-> dec_valid);  // R6

    AST_ERR_FOLLOWS_CFG: assert property (@(posedge clk) disable iff (rst)
        err_pin |-> (status == ($past(cfg_err_sel) ? 2'b01 : 2'b10)));  // R6

    AST_CLEAN_NO_ERR: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && status == 2'b00) |-> !err_pin);  // R7

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
        !dec_valid |-> $stable(status));  // R8

    AST_WRITE_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !tm_en) |=> enc_valid);  // R1

    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && !tm_en) |=> dec_valid);  // R3

    AST_TM_BLOCKS_NORMAL: assert property (@(posedge clk) disable iff (rst)
        (tm_en && !tm_valid) |=> (!enc_valid && !dec_valid));  // R9
endmodule

bind secded_engine secded_engine_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_err_sel (cfg_err_sel),
    .wr_valid    (wr_valid),
    .rd_valid    (rd_valid),
    .tm_en       (tm_en),
    .tm_valid    (tm_valid),
    .enc_valid   (enc_valid),
    .dec_valid   (dec_valid),
    .err_pin     (err_pin),
    .status      (status)
);

// File: tb/secded_engine_tb.sv
`timescale 1ns/1ps
module secded_engine_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_err_sel = 1'b0;
    logic        wr_valid = 1'b0;
    logic [63:0] wr_data = '0;
    logic        rd_valid = 1'b0;
    logic [63:0] rd_data = '0;
    logic [7:0]  rd_chk = '0;
    logic [15:0] rd_tag = '0;
    logic        tm_en = 1'b0;
    logic        tm_op = 1'b0;
    logic        tm_valid = 1'b0;
    logic [63:0] tm_data = '0;
    logic [7:0]  tm_chk = '0;
    logic        enc_valid;
    logic [63:0] enc_data;
    logic [7:0]  enc_chk;
    logic        dec_valid;
    logic [63:0] dec_data;
    logic [15:0] dec_tag;
    logic        err_pin;
    logic [1:0]  status;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [63:0] data;
        logic [7:0]  chk;
        logic [1:0]  st;
        logic        err;
        logic [15:0] tag;
        string       req;
    } exp_t;

    exp_t enc_q[$];
    exp_t dec_q[$];
    exp_t e;

    always #2.5 clk = ~clk;

    secded_engine u_dut (
        .clk(clk), .rst(rst), .cfg_err_sel(cfg_err_sel),
        .wr_valid(wr_valid), .wr_data(wr_data),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_chk(rd_chk), .rd_tag(rd_tag),
        .tm_en(tm_en), .tm_op(tm_op), .tm_valid(tm_valid),
        .tm_data(tm_data), .tm_chk(tm_chk),
        .enc_valid(enc_valid), .enc_data(enc_data), .enc_chk(enc_chk),
        .dec_valid(dec_valid), .dec_data(dec_data), .dec_tag(dec_tag),
        .err_pin(err_pin), .status(status)
    );

    // Check bits per R1: running code position, powers of two skipped
    function automatic logic [7:0] ref_chk(input logic [63:0] d);
        logic [7:0] c;
        int pos;
        c = '0;
        pos = 3;
        for (int i = 0; i < 64; i++) begin
            while ((pos & (pos - 1)) == 0) pos++;
            for (int k = 0; k < 7; k++) begin
                if (((pos >> k) & 1) == 1) c[k] = c[k] ^ d[i];
            end
            pos++;
        end
        c[7] = (^d) ^ (^c[6:0]);
        return c;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Driver tasks: one-cycle request, expectation pushed to the scoreboard
    task automatic do_write(input logic [63:0] d);
        exp_t x;
        @(negedge clk);
        wr_valid = 1'b1; wr_data = d;
        x.data = d; x.chk = ref_chk(d); x.st = 2'b00; x.err = 1'b0; x.tag = '0;
        x.req = "R1";
        enc_q.push_back(x);
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic do_read(input logic [63:0] d, input logic [7:0] c,
                           input logic [15:0] tag, input logic [63:0] exp_d,
                           input logic [1:0] exp_st, input string req);
        exp_t x;
        @(negedge clk);
        rd_valid = 1'b1; rd_data = d; rd_chk = c; rd_tag = tag;
        x.data = exp_d; x.chk = '0; x.st = exp_st; x.tag = tag; x.req = req;
        x.err = cfg_err_sel ? (exp_st == 2'b01) : (exp_st == 2'b10);
        dec_q.push_back(x);
        @(negedge clk);
        rd_valid = 1'b0;
    endtask

    task automatic tm_encode(input logic [63:0] d);
        exp_t x;
        @(negedge clk);
        tm_valid = 1'b1; tm_op = 1'b0; tm_data = d;
        x.data = d; x.chk = ref_chk(d); x.st = 2'b00; x.err = 1'b0; x.tag = '0;
        x.req = "R10";
        enc_q.push_back(x);
        @(negedge clk);
        tm_valid = 1'b0;
    endtask

    task automatic tm_decode(input logic [63:0] d, input logic [7:0] c,
                             input logic [63:0] exp_d, input logic [1:0] exp_st);
        exp_t x;
        @(negedge clk);
        tm_valid = 1'b1; tm_op = 1'b1; tm_data = d; tm_chk = c;
        x.data = exp_d; x.chk = '0; x.st = exp_st; x.tag = '0; x.req = "R11";
        x.err = cfg_err_sel ? (exp_st == 2'b01) : (exp_st == 2'b10);
        dec_q.push_back(x);
        @(negedge clk);
        tm_valid = 1'b0;
    endtask

    // Monitor: pops expectations as results appear
    always @(posedge clk) begin
        #1;
        if (!rst && !done) begin
            if (enc_valid) begin
                if (enc_q.size() == 0) begin
                    check("R9", "unexpected enc_valid", 64'd1, 64'd0);
                end else begin
                    e = enc_q.pop_front();
                    check(e.req, "enc_data", enc_data, e.data);
                    check(e.req, "enc_chk", 64'(enc_chk), 64'(e.chk));
                end
            end
            if (dec_valid) begin
                if (dec_q.size() == 0) begin
                    check("R9", "unexpected dec_valid", 64'd1, 64'd0);
                end else begin
                    e = dec_q.pop_front();
                    check(e.req, "dec_data", dec_data, e.data);
                    check(e.req, "status", 64'(status), 64'(e.st));
                    check("R6", "err_pin", 64'(err_pin), 64'(e.err));
                    check("R6", "dec_tag", 64'(dec_tag), 64'(e.tag));
                end
            end else if (err_pin) begin
                check("R6", "err_pin without dec_valid", 64'd1, 64'd0);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] a;
        logic [63:0] b;
        logic [7:0]  ca;
        logic [7:0]  cb;
        a = 64'hDEAD_BEEF_0123_4567;
        b = 64'hAAAA_5555_F0F0_0F0F;
        ca = ref_chk(a);
        cb = ref_chk(b);

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R2", "status after reset", 64'(status), 64'd0);
        check("R2", "valids after reset", 64'({enc_valid, dec_valid, err_pin}), 64'd0);

        // R1 write encodes
        do_write(64'd0);
        do_write('1);
        do_write(a);
        do_write(b);

        // R7 clean reads
        do_read(a, ca, 16'h0011, a, 2'b00, "R7");
        do_read(64'd0, ref_chk(64'd0), 16'h0012, 64'd0, 2'b00, "R7");

        // cfg 0: pin marks uncorrectable
        do_read(a ^ 64'h1, ca, 16'h0101, a, 2'b01, "R3");
        do_read(b ^ (64'h1 << 63), cb, 16'h0102, b, 2'b01, "R3");
        do_read(a ^ (64'h1 << 31), ca, 16'h0103, a, 2'b01, "R3");
        do_read(a, ca ^ 8'h08, 16'h0201, a, 2'b01, "R5");
        do_read(b, cb ^ 8'h80, 16'h0202, b, 2'b01, "R5");
        do_read(a ^ (64'h1 << 5) ^ (64'h1 << 40), ca, 16'h0301,
                a ^ (64'h1 << 5) ^ (64'h1 << 40), 2'b10, "R4");
        do_read(b ^ (64'h1 << 7), cb ^ 8'h02, 16'h0302,
                b ^ (64'h1 << 7), 2'b10, "R4");
        do_read(a, ca ^ 8'h81, 16'h0303, a, 2'b10, "R4");

        // R8: status sticky through idle cycles and writes
        repeat (5) @(negedge clk);
        check("R8", "status held while idle", 64'(status), 64'd2);
        do_write(b);
        @(negedge clk);
        check("R8", "status held over write", 64'(status), 64'd2);

        // cfg 1: pin marks corrected reads
        @(negedge clk);
        cfg_err_sel = 1'b1;
        do_read(b ^ (64'h1 << 12), cb, 16'h0401, b, 2'b01, "R6");
        do_read(a, ca ^ 8'h01, 16'h0402, a, 2'b01, "R6");
        do_read(a ^ 64'h3, ca, 16'h0403, a ^ 64'h3, 2'b10, "R6");
        do_read(b, cb, 16'h0404, b, 2'b00, "R6");

        // R9: normal requests ignored in test mode
        @(negedge clk);
        tm_en = 1'b1;
        @(negedge clk);
        wr_valid = 1'b1; wr_data = a;
        rd_valid = 1'b1; rd_data = a ^ 64'h3; rd_chk = ca; rd_tag = 16'h0999;
        @(posedge clk);
        #1;
        check("R9", "enc_valid in test mode", 64'(enc_valid), 64'd0);
        check("R9", "dec_valid in test mode", 64'(dec_valid), 64'd0);
        check("R9", "status in test mode", 64'(status), 64'd0);
        @(negedge clk);
        wr_valid = 1'b0; rd_valid = 1'b0;

        // R10 encoder read-back, R11 decoder injection
        tm_encode(a);
        tm_encode(64'h0000_0000_8000_0001);
        check("R10", "status untouched by encode", 64'(status), 64'd0);
        tm_decode(b, cb, b, 2'b00);
        tm_decode(b ^ (64'h1 << 50), cb, b, 2'b01);
        tm_decode(b, cb ^ 8'h40, b, 2'b01);
        @(negedge clk);
        cfg_err_sel = 1'b0;
        tm_decode(a ^ (64'h1 << 2) ^ (64'h1 << 3), ca,
                  a ^ (64'h1 << 2) ^ (64'h1 << 3), 2'b10);
        @(negedge clk);
        tm_en = 1'b0;

        repeat (3) @(negedge clk);
        check("R1", "encode queue drained", 64'(enc_q.size()), 64'd0);
        check("R11", "decode queue drained", 64'(dec_q.size()), 64'd0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule